// File: doc/BRIEF.md
# Multi-mode ADC conversion sequencer

This block sits between a processor's register bus and a successive-approximation converter. It decides which of eight analog channels is handled, when the work begins and how often it repeats. Each channel can be set up for a full conversion or for a fast comparison. A full conversion stores a multi-bit value in that channel's result register. A comparison stores one bit in a shared comparison register. The block counts divided converter-clock ticks to find the end of each operation. It raises a one-cycle interrupt pulse when a one-shot or single-sweep job completes.

Work can be started by software, through a start bit. It can also be started by a falling edge on an external trigger pin. Under the external trigger the start bit only arms the block, and channel 7 is taken out of use. Five modes are offered: one channel once, one channel forever, a single pass over a channel range, and two kinds of endless pass over a range. The analog front end is modelled by a digital sample bus and a comparison bit.

Top module: `adc_seq`

## Requirements
- R1: After reset, every register reads 0, the block is idle, and irq and conv_start are low.
- R2: Control register 0 (address 0) is laid out as follows: bits 2:0 are the channel, bits 4:3 the mode (00 one-shot, 01 repeat, 10 single sweep, 11 endless sweep A), bit 5 the trigger source (1 = external) and bit 6 the start bit. With a software trigger, writing the start bit from 0 to 1 begins work on the chosen channel. A one-shot job ends with a one-cycle irq pulse, and the start bit then reads 0.
- R3: Control register 2 (address 2) selects the operation for each channel: a 1 in bit n makes channel n a comparison. A full conversion lasts 59 converter ticks and a comparison lasts 14. conv_cmp is high while a comparison runs. A conversion result is read at address 8+n. A comparison result goes to bit n of address 3, taken from cmp_in.
- R4: Control register 1 (address 1) bits 6:4 hold a divide exponent e. One converter tick equals 2^min(e,4) clocks. When bit 3 is 0 (10-bit resolution), a divide of 1 is raised to a divide of 2.
- R5: Repeat mode restarts the same channel back to back, with conv_start pulses 59 ticks apart. It raises no irq, and the start bit stays 1.
- R6: Single sweep converts AN0 up to AN(2s+1), where s is control register 1 bits 1:0, in ascending order. It raises irq once, after the last channel. A software trigger then clears the start bit.
- R7: Endless sweep A walks the same range as R6 and wraps to AN0 after the last channel. It never raises irq.
- R8: Setting control register 1 bit 2 selects endless sweep B, whatever the mode bits say. Endless sweep B cycles over AN0 to AN(s).
- R9: With the external trigger, writing the start bit only arms the block. A falling edge on trig_n while the start bit is set begins the job. A further edge during a job restarts it from the beginning. Completion leaves the start bit at 1.
- R10: With the external trigger, a selected channel 7 is served as channel 6, and sweeps end at AN6.
- R11: Writing control register 0 with the start bit at 0 stops any job at once. It writes no result and raises no irq.
- R12: When control register 1 bit 3 is 1 (8-bit resolution), a stored result is sample_in with its two low bits dropped, zero-extended. Otherwise all ten bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0..2) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address (0..3 control/compare, 8..15 results) |
| rd_data | output | 10 | Read data, combinational |
| trig_n | input | 1 | External trigger pin, falling edge active |
| irq | output | 1 | One-cycle completion pulse |
| conv_ch | output | 3 | Channel presented to the converter |
| conv_start | output | 1 | One-cycle pulse at the start of each operation |
| conv_cmp | output | 1 | Current operation is a comparison |
| sample_in | input | 10 | Converter output value |
| cmp_in | input | 1 | Comparator output bit |

## Verification
The bench times the gap from conv_start to irq for every divide setting, including the divide of 1 that 10-bit resolution promotes. A prescaler that is not cleared at launch, or a tick count that is off by one, shows up as a wrong cycle count. It aborts a job partway through and confirms that the channel's result stays zero. A design that stored the value on abort, or pulsed irq, would fail this check. It records the channel order of every sweep mode to catch a missing wrap, a wrong range, or an interrupt in an endless mode. It drives a second trigger edge during a job to confirm the restart, and it selects channel 7 under the external trigger to catch a design that lets AN7 through.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    localparam int CH_W = 3;

    typedef enum logic [2:0] {
        M_ONESHOT,
        M_REPEAT,
        M_SWEEP,
        M_LOOP_A,
        M_LOOP_B
    } mode_e;

    typedef struct packed {
        logic       pad;
        logic       start;
        logic       ext;
        logic [1:0] mode;
        logic [2:0] ch;
    } ctrl0_t;

    typedef struct packed {
        logic       pad;
        logic [2:0] div_exp;
        logic       res8;
        logic       loop_b;
        logic [1:0] span;
    } ctrl1_t;

    function automatic mode_e mode_of(ctrl0_t c0, ctrl1_t c1);
        if (c1.loop_b) return M_LOOP_B;
        case (c0.mode)
            2'b00:   return M_ONESHOT;
            2'b01:   return M_REPEAT;
            2'b10:   return M_SWEEP;
            default: return M_LOOP_A;
        endcase
    endfunction

    function automatic logic is_single_ch(mode_e m);
        return (m == M_ONESHOT) || (m == M_REPEAT);
    endfunction

    // highest channel of a sweep; AN7 is lost to the trigger pin
    function automatic logic [CH_W-1:0] last_of(ctrl0_t c0, ctrl1_t c1, mode_e m);
        logic [CH_W-1:0] l;
        l = (m == M_LOOP_B) ? {1'b0, c1.span} : {c1.span, 1'b1};
        if (c0.ext && l == 3'd7) l = 3'd6;
        return l;
    endfunction

    function automatic logic [CH_W-1:0] first_of(ctrl0_t c0, mode_e m);
        logic [CH_W-1:0] f;
        f = '0;
        if (is_single_ch(m)) begin
            f = c0.ch;
            if (c0.ext && f == 3'd7) f = 3'd6;
        end
        return f;
    endfunction

endpackage

// File: rtl/adc_seq_prescaler.sv
`timescale 1ns/1ps
module adc_seq_prescaler #(
    parameter int MAX_EXP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [2:0] exp_in,
    output logic       tick
);
    localparam int PW = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW:0]   span_full;
    logic [PW-1:0] limit;

    always_comb begin
        span_full = (PW+1)'(1) << exp_in;
        limit     = PW'(span_full - (PW+1)'(1));
        tick      = (cnt_q >= limit);
        cnt_d     = (clr || tick) ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || clr) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_seq_edge.sv
`timescale 1ns/1ps
module adc_seq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_comb sync_d[i] = pin_n;
            end else begin : g_next
                always_comb sync_d[i] = sync_q[i-1];
            end
        end
    endgenerate

    always_comb begin
        prev_d = sync_q[STAGES-1];
        fall   = prev_q & ~sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // R9
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/adc_seq_results.sv
`timescale 1ns/1ps
module adc_seq_results #(
    parameter int NCH   = 8,
    parameter int RES_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     is_cmp,
    input  logic [$clog2(NCH)-1:0]   ch,
    input  logic [RES_W-1:0]         value,
    input  logic                     cmp_bit,
    output logic [RES_W-1:0]         res_o [NCH],
    output logic [NCH-1:0]           cmp_o
);
    logic [NCH-1:0] cmp_q, cmp_d;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic [RES_W-1:0] r_q, r_d;
            always_comb r_d = (we && !is_cmp && ch == i) ? value : r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= '0;
                else        r_q <= r_d;
            end
            assign res_o[i] = r_q;
        end
    endgenerate

    always_comb begin
        cmp_d = cmp_q;
        if (we && is_cmp) cmp_d[ch] = cmp_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign cmp_o = cmp_q;

    // R11
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cmp_q));

endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int CONV_TICKS  = 59,
    parameter int CMP_TICKS   = 14,
    parameter int MAX_EXP     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [3:0]       rd_addr,
    output logic [RES_W-1:0] rd_data,
    input  logic             trig_n,
    output logic             irq,
    output logic [2:0]       conv_ch,
    output logic             conv_start,
    output logic             conv_cmp,
    input  logic [RES_W-1:0] sample_in,
    input  logic             cmp_in
);
    localparam int NCH   = 1 << CH_W;
    localparam int CNT_W = $clog2(CONV_TICKS + 1);

    typedef struct packed {
        logic             run;
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] cnt;
        logic             op_cmp;
        logic             pulse;
        logic             irq;
        ctrl0_t           c0;
        ctrl1_t           c1;
        logic [NCH-1:0]   csel;
    } st_t;

    st_t q, d;

    logic             tick, trig_fall, go, relaunch, finish, res_we;
    logic [2:0]       eff_exp;
    logic [CNT_W-1:0] last_cnt;
    logic [CH_W-1:0]  nxt_ch, last_d;
    mode_e            m_d, m_q;
    logic [RES_W-1:0] res_val;
    logic [RES_W-1:0] res_w [NCH];
    logic [NCH-1:0]   cmp_w;
    logic [7:0]       c0_b, c1_b;

    // divider exponent with saturation and the 10-bit floor
    always_comb begin
        eff_exp = (q.c1.div_exp > 3'(MAX_EXP)) ? 3'(MAX_EXP) : q.c1.div_exp;
        if (!q.c1.res8 && eff_exp == 3'd0) eff_exp = 3'd1;
    end

    adc_seq_prescaler #(.MAX_EXP(MAX_EXP)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go || relaunch),
        .exp_in (eff_exp),
        .tick   (tick)
    );

    adc_seq_edge #(.STAGES(SYNC_STAGES)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (trig_n),
        .fall  (trig_fall)
    );

    always_comb begin
        d        = q;
        d.pulse  = 1'b0;
        d.irq    = 1'b0;
        go       = 1'b0;
        relaunch = 1'b0;
        finish   = 1'b0;
        res_we   = 1'b0;
        last_cnt = q.op_cmp ? CNT_W'(CMP_TICKS - 1) : CNT_W'(CONV_TICKS - 1);

        if (wr_en) begin
            case (wr_addr)
                2'd0: begin
                    d.c0     = ctrl0_t'(wr_data);
                    d.c0.pad = 1'b0;
                    if (!d.c0.start)                  d.run = 1'b0;
                    else if (!d.c0.ext && !q.c0.start) go   = 1'b1;
                end
                2'd1: begin
                    d.c1     = ctrl1_t'(wr_data);
                    d.c1.pad = 1'b0;
                end
                2'd2:    d.csel = wr_data;
                default: ;
            endcase
        end

        if (trig_fall && d.c0.ext && d.c0.start) go = 1'b1;

        m_d    = mode_of(d.c0, d.c1);
        last_d = last_of(d.c0, d.c1, m_d);
        nxt_ch = first_of(d.c0, m_d);

        if (!go && q.run && d.run && tick) begin
            if (q.cnt == last_cnt) begin
                res_we = 1'b1;
                case (m_d)
                    M_ONESHOT: finish = 1'b1;
                    M_REPEAT:  relaunch = 1'b1;
                    M_SWEEP: begin
                        if (q.ch >= last_d) finish = 1'b1;
                        else begin
                            relaunch = 1'b1;
                            nxt_ch   = q.ch + 1'b1;
                        end
                    end
                    default: begin
                        relaunch = 1'b1;
                        nxt_ch   = (q.ch >= last_d) ? '0 : q.ch + 1'b1;
                    end
                endcase
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (finish) begin
            d.irq = 1'b1;
            d.run = 1'b0;
            if (!d.c0.ext) d.c0.start = 1'b0;
        end

        if (go || relaunch) begin
            d.run    = 1'b1;
            d.ch     = nxt_ch;
            d.cnt    = '0;
            d.op_cmp = d.csel[nxt_ch];
            d.pulse  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb res_val = q.c1.res8 ? (sample_in >> (RES_W - 8)) : sample_in;

    adc_seq_results #(.NCH(NCH), .RES_W(RES_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (res_we),
        .is_cmp  (q.op_cmp),
        .ch      (q.ch),
        .value   (res_val),
        .cmp_bit (cmp_in),
        .res_o   (res_w),
        .cmp_o   (cmp_w)
    );

    always_comb begin
        c0_b    = q.c0;
        c1_b    = q.c1;
        rd_data = '0;
        if (rd_addr[3]) begin
            rd_data = res_w[rd_addr[2:0]];
        end else if (!rd_addr[2]) begin
            case (rd_addr[1:0])
                2'd0:    rd_data = RES_W'(c0_b);
                2'd1:    rd_data = RES_W'(c1_b);
                2'd2:    rd_data = RES_W'(q.csel);
                default: rd_data = RES_W'(cmp_w);
            endcase
        end
    end

    assign irq        = q.irq;
    assign conv_ch    = q.ch;
    assign conv_start = q.pulse;
    assign conv_cmp   = q.run & q.op_cmp;
    assign m_q        = mode_of(q.c0, q.c1);

    // R3
    irq_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(q.run));

    // R2
    sw_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !q.c0.ext) |-> !q.c0.start);

    // R9
    ext_start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && q.c0.ext) |-> q.c0.start);

    // R10
    no_ch7_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && q.c0.ext) |-> (conv_ch != 3'd7));

    // R5
    loop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (m_q == M_ONESHOT || m_q == M_SWEEP));

    // R11
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && !wr_data[6]) |=> (!q.run && !irq));

endmodule

// File: tb/tb_adc_seq.sv
`timescale 1ns/1ps
module tb_adc_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] rd_addr;
    logic [9:0] rd_data;
    logic       trig_n;
    logic       irq;
    logic [2:0] conv_ch;
    logic       conv_start;
    logic       conv_cmp;
    logic [9:0] sample_in;
    logic       cmp_in;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // converter model: value and compare bit follow the channel
    assign sample_in = {conv_ch, 7'h53};
    assign cmp_in    = conv_ch[1];

    adc_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_n(trig_n), .irq(irq), .conv_ch(conv_ch),
        .conv_start(conv_start), .conv_cmp(conv_cmp),
        .sample_in(sample_in), .cmp_in(cmp_in)
    );

    // {ch, cmp, exp, res8, expected cycles}
    localparam logic [23:0] VEC [0:6] = '{
        {3'd3, 1'b0, 3'd0, 1'b1, 16'd59},
        {3'd5, 1'b1, 3'd0, 1'b1, 16'd14},
        {3'd0, 1'b0, 3'd2, 1'b0, 16'd236},
        {3'd6, 1'b1, 3'd4, 1'b1, 16'd224},
        {3'd1, 1'b1, 3'd0, 1'b0, 16'd28},
        {3'd7, 1'b0, 3'd7, 1'b1, 16'd944},
        {3'd2, 1'b0, 3'd1, 1'b1, 16'd118}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_res(input logic [2:0] ch, input logic r8);
        logic [9:0] full;
        full = {ch, 7'h53};
        return r8 ? (full >> 2) : full;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [9:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic next_start(input int lim, output bit found, output logic [2:0] ch,
                              output int cyc, output bit saw_irq);
        found = 0; ch = '0; cyc = 0; saw_irq = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            cyc++;
            if (irq) saw_irq = 1;
            if (conv_start) begin
                found = 1; ch = conv_ch;
                return;
            end
        end
    endtask

    task automatic wait_irq(input int lim, output int cyc);
        cyc = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (irq) begin
                cyc = i;
                return;
            end
        end
    endtask

    task automatic trig_pulse();
        @(negedge clk) trig_n = 1'b0;
        @(negedge clk) trig_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [9:0]  v;
        logic [2:0]  ch;
        bit          found, sirq;
        int          cyc;

        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; trig_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); chk(v == 0, "R1 ctrl0", v, 0);
        rd(4'd1, v); chk(v == 0, "R1 ctrl1", v, 0);
        rd(4'd8, v); chk(v == 0, "R1 result0", v, 0);
        chk(!irq && !conv_start, "R1 outputs idle", {irq, conv_start}, 0);

        // R11 abort partway through a one-shot on channel 4
        wr(2'd1, 8'h08);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h44);
        next_start(10, found, ch, cyc, sirq);
        chk(found && ch == 3'd4, "R11 launch ch4", ch, 4);
        repeat (20) @(negedge clk);
        wr(2'd0, 8'h04);
        next_start(200, found, ch, cyc, sirq);
        chk(!found && !sirq, "R11 no restart or irq", {found, sirq}, 0);
        rd(4'd12, v); chk(v == 0, "R11 result4 untouched", v, 0);

        // R2 R3 R4 R12 one-shot table
        for (int k = 0; k < 7; k++) begin
            logic [2:0]  vch;
            logic        vcmp, vr8;
            logic [2:0]  vexp;
            int          vcyc;
            vch  = VEC[k][23:21];
            vcmp = VEC[k][20];
            vexp = VEC[k][19:17];
            vr8  = VEC[k][16];
            vcyc = int'(VEC[k][15:0]);
            wr(2'd1, {1'b0, vexp, vr8, 1'b0, 2'b00});
            wr(2'd2, vcmp ? (8'h01 << vch) : 8'h00);
            wr(2'd0, {1'b0, 1'b1, 1'b0, 2'b00, vch});
            next_start(10, found, ch, cyc, sirq);
            chk(found && ch == vch, "R2 channel select", ch, vch);
            chk(conv_cmp == vcmp, "R3 operation kind", conv_cmp, vcmp);
            wait_irq(2000, cyc);
            chk(cyc == vcyc, "R4 R3 operation length", cyc, vcyc);
            @(negedge clk);
            chk(!irq, "R2 irq single pulse", irq, 0);
            if (vcmp) begin
                rd(4'd3, v);
                chk(v[vch] == vch[1], "R3 compare bit", v[vch], vch[1]);
            end else begin
                rd({1'b1, vch}, v);
                chk(v == exp_res(vch, vr8), "R12 R2 result value", v, exp_res(vch, vr8));
            end
            rd(4'd0, v);
            chk(v[6] == 1'b0, "R2 start cleared", v[6], 0);
        end

        // R5 repeat mode on channel 4
        wr(2'd1, 8'h08);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h4C);
        next_start(10, found, ch, cyc, sirq);
        for (int k = 0; k < 2; k++) begin
            next_start(200, found, ch, cyc, sirq);
            chk(found && ch == 3'd4 && cyc == 59 && !sirq, "R5 repeat gap", cyc, 59);
        end
        rd(4'd0, v); chk(v[6] == 1'b1, "R5 start kept", v[6], 1);
        rd(4'd12, v); chk(v == exp_res(3'd4, 1'b1), "R5 result stored", v, exp_res(3'd4, 1'b1));
        wr(2'd0, 8'h00);

        // R6 single sweep over AN0..AN3, all comparisons
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h09);
        wr(2'd0, 8'h50);
        for (int k = 0; k < 4; k++) begin
            next_start(100, found, ch, cyc, sirq);
            chk(found && ch == k[2:0] && !sirq, "R6 sweep order", ch, k);
            if (k > 0) chk(cyc == 14, "R6 sweep step", cyc, 14);
        end
        next_start(100, found, ch, cyc, sirq);
        chk(!found && sirq, "R6 stop with irq", {found, sirq}, 1);
        rd(4'd0, v); chk(v[6] == 1'b0, "R6 start cleared", v[6], 0);
        rd(4'd3, v); chk(v[3:0] == 4'b1100, "R6 compare bits", v[3:0], 12);

        // R7 endless sweep A over AN0..AN1
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h58);
        for (int k = 0; k < 5; k++) begin
            next_start(100, found, ch, cyc, sirq);
            chk(found && ch == 3'(k % 2) && !sirq, "R7 wrap order", ch, k % 2);
        end
        wr(2'd0, 8'h00);

        // R8 endless sweep B over AN0..AN2 despite one-shot mode bits
        wr(2'd1, 8'h0E);
        wr(2'd0, 8'h45);
        for (int k = 0; k < 4; k++) begin
            next_start(100, found, ch, cyc, sirq);
            chk(found && ch == 3'(k % 3) && !sirq, "R8 sweep B order", ch, k % 3);
        end
        wr(2'd0, 8'h00);

        // R9 R10 external trigger, channel 7 selected
        wr(2'd1, 8'h08);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h67);
        next_start(40, found, ch, cyc, sirq);
        chk(!found, "R9 write only arms", found, 0);
        trig_pulse();
        next_start(20, found, ch, cyc, sirq);
        chk(found && ch == 3'd6, "R10 ch7 served as ch6", ch, 6);
        repeat (20) @(negedge clk);
        trig_pulse();
        next_start(20, found, ch, cyc, sirq);
        chk(found && !sirq, "R9 restart on edge", found, 1);
        wait_irq(200, cyc);
        chk(cyc == 59, "R9 full length after restart", cyc, 59);
        rd(4'd0, v); chk(v[6] == 1'b1, "R9 start kept", v[6], 1);
        rd(4'd14, v); chk(v == exp_res(3'd6, 1'b1), "R9 result ch6", v, exp_res(3'd6, 1'b1));

        // R10 external single sweep with full range stops at AN6
        wr(2'd1, 8'h0B);
        wr(2'd0, 8'h70);
        trig_pulse();
        for (int k = 0; k < 7; k++) begin
            next_start(100, found, ch, cyc, sirq);
            chk(found && ch == k[2:0], "R10 ext sweep order", ch, k);
        end
        next_start(100, found, ch, cyc, sirq);
        chk(!found && sirq, "R10 sweep ends at AN6", {found, sirq}, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule